// File: doc/BRIEF.md
# DRAM init command sequencer

This block brings a DDR3 device from power-up to a usable state by issuing a fixed sequence of commands through a memory controller's direct-command register. A start request makes it ask the controller for power-up. Once the controller reports power-up complete, it writes the command words one at a time. After each write it polls the returned start flag. When that flag reads back as zero, it moves on to the next command.

Every command word carries a start flag, a rank mask that selects both ranks, a bank address, a 13-bit address field and a 4-bit operation code. The four mode-register values are inputs to the block. A settle interval of programmable length separates the opening deselect from the precharge-all. After the long ZQ calibration completes, a done flag rises and stays high until the next start.

Top module: `dinit_cmd_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, pu_req, cmd_wr and done are all 0.
- R2: A start seen in the idle or done state drives pu_req high from the next cycle on. pu_req holds until pu_done is sampled high, and no command word is written before that.
- R3: Each command word has bit 31 (start flag) at 1 and the rank mask field, bits 30:20, equal to 3 (both ranks). The bank sits in bits 19:17, the address in bits 16:4 and the operation code in bits 3:0.
- R4: Exactly seven words are written per run, in this order: deselect (code 0), precharge-all (code 1), mode-register set (code 3) to bank 2, to bank 3, to bank 1 and to bank 0, then ZQ long calibration (code 5). Deselect, precharge-all and ZQ carry bank 0 and address 0.
- R5: The address field of the mode-register writes to banks 2, 3 and 1 is the low 13 bits of mr2, mr3 and mr1 respectively. Input bits above bit 12 have no effect.
- R6: The bank-0 mode-register write carries the low 13 bits of mr0 with address bit 8 (DLL reset, word bit 12) forced to 1.
- R7: cmd_wr is a single-cycle pulse. The next word is written in the cycle after the first cycle in which cmd_go_rd is sampled low following a write. No write occurs while cmd_go_rd is high.
- R8: After the deselect completes, the block waits GAP_CYCLES idle cycles before writing the precharge-all.
- R9: done rises in the cycle after the ZQ command's start flag is seen clear. It stays high until a start is sampled, which clears it and begins a new run.
- R10: A start that arrives while a run is in progress, including in the cycle in which the ZQ completion is sampled, is ignored: pu_req stays low and the run ends normally with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a power-up and init run |
| pu_done | input | 1 | Controller reports power-up complete |
| mr0 | input | MR_IN_W | Mode register 0 value |
| mr1 | input | MR_IN_W | Mode register 1 value |
| mr2 | input | MR_IN_W | Mode register 2 value |
| mr3 | input | MR_IN_W | Mode register 3 value |
| cmd_go_rd | input | 1 | Start flag read back from the command register |
| pu_req | output | 1 | Power-up start request to the controller |
| cmd_wr | output | 1 | Write strobe for the command register |
| cmd_word | output | 32 | Command word to write |
| done | output | 1 | Init sequence complete |

## Verification
Two events can fall in the same cycle: a fresh start request and the completion of the final ZQ command, which is the moment the done flag is about to rise. The bench watches its own executor model. When the last command's busy flag drops, it raises start for exactly the cycle in which the sequencer samples the clear. The expected result is that this start is ignored: done rises on schedule and pu_req stays low. A start one cycle later must then clear done and begin a full new run. Beyond that, every cycle's pu_req, cmd_wr, command word and done are compared against a behavioural reference that runs under executor latencies that vary per command.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  // Command word layout (fixed by the controller that decodes it)
  localparam int WORD_W    = 32;
  localparam int GO_BIT    = 31;
  localparam int RANK_LSB  = 20;
  localparam int RANK_W    = 11;
  localparam int BANK_LSB  = 17;
  localparam int BANK_W    = 3;
  localparam int ADDR_LSB  = 4;
  localparam int ADDR_W    = 13;
  localparam int OP_W      = 4;
  localparam int DLL_RST_BIT = 8;
  localparam logic [RANK_W-1:0] ALL_RANKS = RANK_W'(3);

  localparam int N_STEPS = 7;
  localparam int STEP_W  = $clog2(N_STEPS);

  typedef enum logic [OP_W-1:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQS   = 4'd4,
    OP_ZQL   = 4'd5,
    OP_RSTL  = 4'd6,
    OP_MRR   = 4'd8
  } dcmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PWR, S_ISSUE, S_WAIT, S_GAP, S_DONE
  } seq_st_e;

  typedef struct packed {
    dcmd_e             op;
    logic [BANK_W-1:0] bank;
    logic [1:0]        mr_sel;
    logic              use_mr;
    logic              dll_rst;
  } step_t;

  // Ordered init program
  function automatic step_t step_of(int i);
    step_t s;
    s = '{op: OP_DESEL, bank: '0, mr_sel: 2'd0, use_mr: 1'b0, dll_rst: 1'b0};
    case (i)
      1: s.op = OP_PREA;
      2: begin s.op = OP_MRS; s.bank = 3'd2; s.mr_sel = 2'd2; s.use_mr = 1'b1; end
      3: begin s.op = OP_MRS; s.bank = 3'd3; s.mr_sel = 2'd3; s.use_mr = 1'b1; end
      4: begin s.op = OP_MRS; s.bank = 3'd1; s.mr_sel = 2'd1; s.use_mr = 1'b1; end
      5: begin s.op = OP_MRS; s.bank = 3'd0; s.mr_sel = 2'd0; s.use_mr = 1'b1;
               s.dll_rst = 1'b1; end
      6: s.op = OP_ZQL;
      default: ;
    endcase
    return s;
  endfunction

  // Step after which a settle interval is inserted
  function automatic logic gap_after(logic [STEP_W-1:0] i);
    return i == STEP_W'(0);
  endfunction

  function automatic logic [WORD_W-1:0] pack_cmd(logic [RANK_W-1:0] rank,
                                                 logic [BANK_W-1:0] bank,
                                                 logic [ADDR_W-1:0] addr,
                                                 dcmd_e op);
    logic [WORD_W-1:0] w;
    w = '0;
    w[GO_BIT]                = 1'b1;
    w[RANK_LSB +: RANK_W]    = rank;
    w[BANK_LSB +: BANK_W]    = bank;
    w[ADDR_LSB +: ADDR_W]    = addr;
    w[OP_W-1:0]              = op;
    return w;
  endfunction

endpackage

// File: rtl/dinit_steps.sv
module dinit_steps
  import dinit_pkg::*;
#(
  parameter int MR_IN_W = 16
) (
  input  logic [MR_IN_W-1:0] mr0,
  input  logic [MR_IN_W-1:0] mr1,
  input  logic [MR_IN_W-1:0] mr2,
  input  logic [MR_IN_W-1:0] mr3,
  input  logic [STEP_W-1:0]  idx,
  output logic [WORD_W-1:0]  word
);

  logic [ADDR_W-1:0] mr_lo [4];
  logic [WORD_W-1:0] words [N_STEPS];

  assign mr_lo[0] = ADDR_W'(mr0);
  assign mr_lo[1] = ADDR_W'(mr1);
  assign mr_lo[2] = ADDR_W'(mr2);
  assign mr_lo[3] = ADDR_W'(mr3);

  for (genvar s = 0; s < N_STEPS; s++) begin : g_step
    localparam step_t ST = step_of(s);
    logic [ADDR_W-1:0] addr_s;
    always_comb begin
      addr_s = '0;
      if (ST.use_mr) addr_s = mr_lo[ST.mr_sel];
      if (ST.dll_rst) addr_s[DLL_RST_BIT] = 1'b1;
    end
    assign words[s] = pack_cmd(ALL_RANKS, ST.bank, addr_s, ST.op);
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < N_STEPS; i++)
      if (idx == STEP_W'(i)) word = words[i];
  end

endmodule

// File: rtl/dinit_gap_timer.sv
module dinit_gap_timer #(
  parameter int GAP_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R8
  gap_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/dinit_fsm.sv
module dinit_fsm
  import dinit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pu_done,
  input  logic              go_rd,
  input  logic              gap_expired,
  output logic              pu_req,
  output logic              cmd_wr,
  output logic              done,
  output logic              gap_run,
  output logic [STEP_W-1:0] idx
);

  seq_st_e st;
  logic    ev_cmd_clear;
  logic    last_step;

  assign ev_cmd_clear = (st == S_WAIT) && !go_rd;
  assign last_step    = idx == STEP_W'(N_STEPS - 1);

  assign pu_req  = st == S_PWR;
  assign cmd_wr  = st == S_ISSUE;
  assign done    = st == S_DONE;
  assign gap_run = st == S_GAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
    end else begin
      case (st)
        S_IDLE:  if (start) st <= S_PWR;
        S_PWR:   if (pu_done) begin st <= S_ISSUE; idx <= '0; end
        S_ISSUE: st <= S_WAIT;
        S_WAIT:  if (ev_cmd_clear) begin
                   if (last_step)          st <= S_DONE;
                   else if (gap_after(idx)) st <= S_GAP;
                   else begin idx <= idx + 1'b1; st <= S_ISSUE; end
                 end
        S_GAP:   if (gap_expired) begin idx <= idx + 1'b1; st <= S_ISSUE; end
        S_DONE:  if (start) st <= S_PWR;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pu_req, cmd_wr, done}));

  // R2
  pu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pu_req && !pu_done |=> pu_req);

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !cmd_wr);

  // R7
  wr_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> !go_rd);

  // R8
  gap_then_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_run && gap_expired |=> cmd_wr);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R10
  run_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {S_ISSUE, S_WAIT, S_GAP}) |=> !pu_req);

endmodule

// File: rtl/dinit_cmd_seq.sv
module dinit_cmd_seq
  import dinit_pkg::*;
#(
  parameter int MR_IN_W    = 16,
  parameter int GAP_CYCLES = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               pu_done,
  input  logic [MR_IN_W-1:0] mr0,
  input  logic [MR_IN_W-1:0] mr1,
  input  logic [MR_IN_W-1:0] mr2,
  input  logic [MR_IN_W-1:0] mr3,
  input  logic               cmd_go_rd,
  output logic               pu_req,
  output logic               cmd_wr,
  output logic [WORD_W-1:0]  cmd_word,
  output logic               done
);

  logic              gap_run;
  logic              gap_expired;
  logic [STEP_W-1:0] idx;

  dinit_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pu_done     (pu_done),
    .go_rd       (cmd_go_rd),
    .gap_expired (gap_expired),
    .pu_req      (pu_req),
    .cmd_wr      (cmd_wr),
    .done        (done),
    .gap_run     (gap_run),
    .idx         (idx)
  );

  dinit_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (gap_run),
    .expired (gap_expired)
  );

  dinit_steps #(.MR_IN_W(MR_IN_W)) u_steps (
    .mr0  (mr0),
    .mr1  (mr1),
    .mr2  (mr2),
    .mr3  (mr3),
    .idx  (idx),
    .word (cmd_word)
  );

  // R3
  go_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> cmd_word[GO_BIT] && (cmd_word[RANK_LSB +: RANK_W] == ALL_RANKS));

endmodule

// File: tb/tb_dinit_cmd_seq.sv
module tb_dinit_cmd_seq;
  localparam int GAP = 50;
  localparam int MRW = 16;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n = 0;
  logic start_a = 0, start_b = 0;
  logic start;
  logic pu_done = 0;
  logic [MRW-1:0] mr0, mr1, mr2, mr3;
  logic busy = 0;
  logic pu_req, cmd_wr, done;
  logic [31:0] cmd_word;

  assign start = start_a | start_b;

  dinit_cmd_seq #(.MR_IN_W(MRW), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pu_done(pu_done),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3), .cmd_go_rd(busy),
    .pu_req(pu_req), .cmd_wr(cmd_wr), .cmd_word(cmd_word), .done(done));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int bank, int addr, int code);
    return 32'h8000_0000 | (32'd3 << 20) | (32'(bank) << 17)
         | (32'(addr & 'h1fff) << 4) | 32'(code);
  endfunction

  // Executor model: busy from the write until a per-command latency expires
  bit wr_s = 0;
  int bcnt = 0, nwr = 0;
  always @(negedge clk) wr_s = cmd_wr;
  always @(posedge clk) begin
    if (!rst_n) busy <= 0;
    else if (wr_s) begin
      busy <= 1; bcnt = 1 + (nwr * 3) % 5; nwr++;
    end else if (busy) begin
      bcnt--;
      if (bcnt <= 0) busy <= 0;
    end
  end

  // Reference model
  int mph = 0, k = 0, g = 0;
  logic [31:0] q[$];
  always @(posedge clk) begin
    if (!rst_n) begin mph = 0; k = 0; g = 0; end
    else case (mph)
      0: if (start) mph = 1;
      1: if (pu_done) begin
           q.delete();
           q.push_back(mk(0, 0, 0));
           q.push_back(mk(0, 0, 1));
           q.push_back(mk(2, int'(mr2), 3));
           q.push_back(mk(3, int'(mr3), 3));
           q.push_back(mk(1, int'(mr1), 3));
           q.push_back(mk(0, int'(mr0) | 'h100, 3));
           q.push_back(mk(0, 0, 5));
           k = 0; mph = 2;
         end
      2: mph = 3;
      3: if (!busy) begin
           if (k == 6) mph = 5;
           else if (k == 0) begin g = 0; mph = 4; end
           else begin k++; mph = 2; end
         end
      4: if (g == GAP - 1) begin k++; mph = 2; end else g++;
      5: if (start) mph = 1;
      default: mph = 0;
    endcase
  end

  // Per-cycle comparison
  int words_run = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(pu_req === (mph == 1), "R2 pu_req", 32'(pu_req), 32'(mph == 1));
      chk(cmd_wr === (mph == 2), (mph == 4 || (mph == 2 && k == 1)) ? "R8 cmd_wr" : "R7 cmd_wr",
          32'(cmd_wr), 32'(mph == 2));
      chk(done === (mph == 5), "R9 done", 32'(done), 32'(mph == 5));
      if (cmd_wr && mph == 2) begin
        words_run++;
        chk(cmd_word === q[k], (k == 5) ? "R6 word" : (k >= 2 && k <= 4) ? "R5 word" : "R4 word",
            cmd_word, q[k]);
        chk(cmd_word[31] === 1'b1 && cmd_word[30:20] === 11'd3, "R3 go/rank",
            cmd_word, q[k]);
      end
    end
  end

  // Collision: start in the cycle the ZQ completion is sampled
  bit arm = 0, collided = 0;
  always @(negedge clk) begin
    if (arm && mph == 3 && k == 6 && !busy) begin
      start_b = 1; arm = 0; collided = 1;
    end else start_b = 0;
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 32'(done), 32'd1);
    summary();
  end

  initial begin
    mr0 = 16'hF520; mr1 = 16'hA044; mr2 = 16'h6018; mr3 = 16'h0004;
    repeat (3) @(negedge clk);
    chk(!pu_req && !cmd_wr && !done, "R1 reset", {29'd0, pu_req, cmd_wr, done}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!pu_req && !cmd_wr && !done, "R1 release", {29'd0, pu_req, cmd_wr, done}, 32'd0);

    // Run 1: delayed power-up, mode registers with high bits set
    start_a = 1; @(negedge clk); start_a = 0;
    chk(pu_req === 1'b1, "R2 request", 32'(pu_req), 32'd1);
    repeat (5) begin
      @(negedge clk);
      chk(pu_req === 1'b1 && cmd_wr === 1'b0, "R2 hold", {30'd0, pu_req, cmd_wr}, 32'd2);
    end
    pu_done = 1;
    while (!(mph == 3 && k == 2)) @(negedge clk);
    start_a = 1; @(negedge clk); start_a = 0;
    chk(pu_req === 1'b0, "R10 mid-run start", 32'(pu_req), 32'd0);
    while (!done) @(negedge clk);
    chk(words_run == 7, "R4 count", 32'(words_run), 32'd7);
    repeat (10) begin
      @(negedge clk);
      chk(done === 1'b1, "R9 hold", 32'(done), 32'd1);
    end

    // Run 2: different values, start collides with ZQ completion
    mr0 = 16'h0E00; mr1 = 16'hFFFF; mr2 = 16'h0000; mr3 = 16'h2003;
    words_run = 0;
    arm = 1;
    start_a = 1; @(negedge clk); start_a = 0;
    chk(done === 1'b0 && pu_req === 1'b1, "R9 restart", {30'd0, done, pu_req}, 32'd1);
    wait (collided);
    @(negedge clk);
    chk(done === 1'b1 && pu_req === 1'b0, "R10 collide", {30'd0, done, pu_req}, 32'd2);
    chk(words_run == 7, "R4 count2", 32'(words_run), 32'd7);

    // Run 3: restart right after, power-up already reported
    mr0 = 16'h1FFF; mr1 = 16'h0001; mr2 = 16'hE00F; mr3 = 16'h1000;
    words_run = 0;
    start_a = 1; @(negedge clk); start_a = 0;
    chk(done === 1'b0, "R9 clear", 32'(done), 32'd0);
    while (!done) @(negedge clk);
    chk(words_run == 7, "R4 count3", 32'(words_run), 32'd7);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule